// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is a per-core event-counting unit controlled through a simple word-addressed register bus. It holds one dedicated 32-bit cycle counter and a parameterized set of 32-bit general event counters. Each general counter has a type register that picks an event source and filters counting by the current privilege level. Software reaches a general counter's value and type indirectly, by first writing a select register. Counter enables and interrupt enables are bitmaps written through separate set and clear addresses. An overflow status bitmap records counter wraps, and a level interrupt stays asserted while any enabled overflow flag is pending.

Event sources are a vector of single-cycle event pulses, a fixed "every clock" event and a software increment register. A global control register enables all counting, clears counters, and can slow the cycle counter to one step per 64 clocks. A user-access bit decides whether code at user privilege may read counter values. Reads are combinational from the address; writes take effect at the next rising clock edge. All state resets to zero.

Top module: `perf_mon_unit`

## Requirements
- R1: Register addresses: 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow status, 6 software increment, 7 select, 8 selected count, 9 selected type, 10 cycle count, 11 user access. Reading the control register returns written bits [5:0] with bits 1 and 2 always 0, and bits [15:11] hold NUM_EVT; all other bits read 0 and all registers reset to 0.
- R2: A control write with bit 1 set zeroes every general counter, and one with bit 2 set zeroes the cycle counter and its 64-clock prescaler, at that write's clock edge; the clear wins over an increment at the same edge.
- R3: The cycle counter advances by one on each clock edge while control bit 0 and enable bit 31 are both set; with control bit 3 also set it advances once every 64 edges; with control bit 0 clear no counter advances.
- R4: In the enable and interrupt-enable bitmaps, general counter n is bit n and the cycle counter is bit 31; writing 1 to a bit at the set address sets it, at the clear address clears it, writing 0 changes nothing, and unimplemented bits read 0. Either address reads the bitmap.
- R5: When a counter steps from 0xFFFFFFFF to 0, its overflow flag (same bit layout as R4) is set at that edge; writing 1 to an overflow bit clears it, and a wrap at the same edge wins.
- R6: The interrupt output is high exactly while some overflow flag has its interrupt-enable bit set.
- R7: The select register (bits [4:0]) picks general counter n for the selected count and selected type addresses; a selection of NUM_EVT or more reads 0 at both and writes there change no counter.
- R8: Type writes keep only bits under mask 0xC80003FF. Event number bits [9:0]: 0x11 counts every edge, 0x00 counts on a software-increment write with bit n set, any other value below NUM_LINES counts when ev_i at that index is high, and larger values never count.
- R9: Privilege encoding 0 user, 1 kernel, 2 hypervisor, 3 none. Type bit 30 blocks counting at user level, bit 31 blocks kernel level, bit 27 permits hypervisor level, and level 3 never counts; the cycle counter has no filter.
- R10: At user level with user-access bit 0 clear, the selected count and cycle count addresses read 0; a write to the user-access register made at user level is ignored.
- R11: Writing the selected count or cycle count loads the value at that edge, taking precedence over an increment, and a loaded value never sets an overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| priv_i | input | 2 | Current privilege level |
| ev_i | input | NUM_LINES | Event pulses, one per source |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
On every cycle the assertions check that the read-only counter-count field appears in the control readout, that clear bits zero the counters at the next edge, that the cycle counter holds while globally disabled, that set writes and wraps reach their bitmap bits, and that the interrupt only rises after a wrap or an interrupt-enable set and only falls after a flag or enable clear. The bench's scenarios are needed for the counting arithmetic itself: event-number decoding across every source line, the full privilege-by-filter matrix, the 64-clock prescaler ratio, software increments, indirect selection out of range and user-level read gating.

// File: rtl/pmu_pkg.sv
// Shared constants and helpers for the performance monitor counter unit.
// Assumes word-addressed 4-bit register bus and 32-bit counters.
package pmu_pkg;

    localparam int CNT_W   = 32;
    localparam int CYC_BIT = 31;

    localparam logic [3:0] A_CTRL     = 4'd0;
    localparam logic [3:0] A_EN_SET   = 4'd1;
    localparam logic [3:0] A_EN_CLR   = 4'd2;
    localparam logic [3:0] A_IE_SET   = 4'd3;
    localparam logic [3:0] A_IE_CLR   = 4'd4;
    localparam logic [3:0] A_OVF      = 4'd5;
    localparam logic [3:0] A_SWINC    = 4'd6;
    localparam logic [3:0] A_SEL      = 4'd7;
    localparam logic [3:0] A_SEL_CNT  = 4'd8;
    localparam logic [3:0] A_SEL_TYPE = 4'd9;
    localparam logic [3:0] A_CYC      = 4'd10;
    localparam logic [3:0] A_USER     = 4'd11;

    localparam logic [31:0] TYPE_MASK = 32'hC800_03FF;
    localparam logic [5:0]  CTRL_KEEP = 6'b111001;
    localparam logic [9:0]  EV_CYCLES = 10'h011;
    localparam logic [9:0]  EV_SWINC  = 10'h000;

    typedef enum logic [1:0] {
        PRIV_USER   = 2'd0,
        PRIV_KERNEL = 2'd1,
        PRIV_HYP    = 2'd2,
        PRIV_NONE   = 2'd3
    } priv_e;

    // Decide whether a type word permits counting at a privilege level.
    function automatic logic priv_allows(input logic [31:0] typ, input logic [1:0] lvl);
        logic ok;
        case (lvl)
            PRIV_USER:   ok = !typ[30];
            PRIV_KERNEL: ok = !typ[31];
            PRIV_HYP:    ok = typ[27];
            default:     ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pmu_evt_counter.sv
// One general event counter with its type register.
// Assumes NUM_LINES below 1024; clear beats load, load beats increment.
module pmu_evt_counter
    import pmu_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 glob_en_i,
    input  logic                 cnt_en_i,
    input  logic [1:0]           priv_i,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic                 sw_inc_i,
    input  logic                 clr_i,
    input  logic                 wr_cnt_i,
    input  logic                 wr_type_i,
    input  logic [CNT_W-1:0]     wdata_i,
    output logic [CNT_W-1:0]     count_o,
    output logic [31:0]          type_o,
    output logic                 wrap_o
);
    localparam int EXT_W = 1024;

    logic [CNT_W-1:0] count_q;
    logic [31:0]      type_q;
    logic [EXT_W-1:0] lines_ext;
    logic [9:0]       evnum;
    logic             hit;
    logic             inc;

    assign lines_ext = {{(EXT_W-NUM_LINES){1'b0}}, lines_i};
    assign evnum     = type_q[9:0];

    // Pick the event source named by the type register.
    always_comb begin
        if (evnum == EV_CYCLES)     hit = 1'b1;
        else if (evnum == EV_SWINC) hit = sw_inc_i;
        else                        hit = lines_ext[evnum];
    end

    assign inc = glob_en_i & cnt_en_i & priv_allows(type_q, priv_i) & hit;

    // Count register: clear, then load, then increment.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       count_q <= '0;
        else if (clr_i)    count_q <= '0;
        else if (wr_cnt_i) count_q <= wdata_i;
        else if (inc)      count_q <= count_q + 1'b1;
    end

    // Type register keeps only writable bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        type_q <= '0;
        else if (wr_type_i) type_q <= wdata_i & TYPE_MASK;
    end

    assign wrap_o  = inc & !clr_i & !wr_cnt_i & (&count_q);
    assign count_o = count_q;
    assign type_o  = type_q;
endmodule

// File: rtl/pmu_cyc_counter.sv
// Dedicated cycle counter with optional divide-by-64 prescaler.
// Assumes run_i already combines global and per-counter enables.
module pmu_cyc_counter
    import pmu_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             div_i,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [DIV_LOG2-1:0] PRESC_LAST = '1;

    logic [DIV_LOG2-1:0] presc_q;
    logic [CNT_W-1:0]    count_q;
    logic                tick;

    // Prescaler advances only while running in divided mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             presc_q <= '0;
        else if (clr_i)          presc_q <= '0;
        else if (run_i && div_i) presc_q <= presc_q + 1'b1;
    end

    assign tick = run_i & (!div_i | (presc_q == PRESC_LAST));

    // Count register: clear, then load, then tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    count_q <= '0;
        else if (clr_i) count_q <= '0;
        else if (wr_i)  count_q <= wdata_i;
        else if (tick)  count_q <= count_q + 1'b1;
    end

    assign wrap_o  = tick & !clr_i & !wr_i & (&count_q);
    assign count_o = count_q;
endmodule

// File: rtl/pmu_bitmap.sv
// Bitmap register written through separate set and clear strobes.
// Assumes KEEP marks implemented bits; others stay zero.
module pmu_bitmap #(
    parameter int           W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] bits_o
);
    logic [W-1:0] bits_q;

    // Apply write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    bits_q <= '0;
        else if (set_i) bits_q <= (bits_q | wdata_i) & KEEP;
        else if (clr_i) bits_q <= bits_q & ~wdata_i;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/perf_mon_unit.sv
// Performance monitor counter unit: control, bitmaps, indirect access,
// overflow tracking and interrupt. Assumes 1 <= NUM_EVT <= 30.
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int NUM_EVT   = 4,
    parameter int NUM_LINES = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_wr_i,
    input  logic [3:0]           bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    input  logic [1:0]           priv_i,
    input  logic [NUM_LINES-1:0] ev_i,
    output logic                 irq_o
);
    localparam logic [31:0] IMPL_MASK = ((32'h1 << NUM_EVT) - 32'h1) | 32'h8000_0000;
    localparam logic [4:0]  NUM_EVT_F = 5'(NUM_EVT);

    logic [5:0]       ctrl_q;
    logic [4:0]       sel_q;
    logic             user_q;
    logic [31:0]      en_q;
    logic [31:0]      ie_q;
    logic [31:0]      ovf_q;
    logic [31:0]      wrap_vec;
    logic [31:0]      swinc_vec;
    logic [CNT_W-1:0] cyc_count;
    logic             cyc_wrap;
    logic [CNT_W-1:0] evt_count [NUM_EVT];
    logic [31:0]      evt_type  [NUM_EVT];
    logic [NUM_EVT-1:0] evt_wrap;
    logic [CNT_W-1:0] sel_count;
    logic [31:0]      sel_type;
    logic             sel_valid;
    logic             clr_evt;
    logic             clr_cyc;
    logic             user_blocked;

    // Decoded write strobes.
    logic wr_ctrl, wr_ovf, wr_sel, wr_user, wr_cyc, wr_sel_cnt, wr_sel_type;
    assign wr_ctrl     = bus_wr_i && bus_addr_i == A_CTRL;
    assign wr_ovf      = bus_wr_i && bus_addr_i == A_OVF;
    assign wr_sel      = bus_wr_i && bus_addr_i == A_SEL;
    assign wr_user     = bus_wr_i && bus_addr_i == A_USER && priv_i != PRIV_USER;
    assign wr_cyc      = bus_wr_i && bus_addr_i == A_CYC;
    assign wr_sel_cnt  = bus_wr_i && bus_addr_i == A_SEL_CNT;
    assign wr_sel_type = bus_wr_i && bus_addr_i == A_SEL_TYPE;
    assign swinc_vec   = (bus_wr_i && bus_addr_i == A_SWINC) ? bus_wdata_i : '0;
    assign clr_evt     = wr_ctrl & bus_wdata_i[1];
    assign clr_cyc     = wr_ctrl & bus_wdata_i[2];

    // Control, select and user-access registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            user_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata_i[5:0] & CTRL_KEEP;
            if (wr_sel)  sel_q  <= bus_wdata_i[4:0];
            if (wr_user) user_q <= bus_wdata_i[0];
        end
    end

    pmu_bitmap #(.W(32), .KEEP(IMPL_MASK)) i_en_bits (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (bus_wr_i && bus_addr_i == A_EN_SET),
        .clr_i   (bus_wr_i && bus_addr_i == A_EN_CLR),
        .wdata_i (bus_wdata_i),
        .bits_o  (en_q)
    );

    pmu_bitmap #(.W(32), .KEEP(IMPL_MASK)) i_ie_bits (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (bus_wr_i && bus_addr_i == A_IE_SET),
        .clr_i   (bus_wr_i && bus_addr_i == A_IE_CLR),
        .wdata_i (bus_wdata_i),
        .bits_o  (ie_q)
    );

    pmu_cyc_counter i_cyc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (ctrl_q[0] & en_q[CYC_BIT]),
        .div_i   (ctrl_q[3]),
        .clr_i   (clr_cyc),
        .wr_i    (wr_cyc),
        .wdata_i (bus_wdata_i),
        .count_o (cyc_count),
        .wrap_o  (cyc_wrap)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        pmu_evt_counter #(.NUM_LINES(NUM_LINES)) i_evt (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .glob_en_i (ctrl_q[0]),
            .cnt_en_i  (en_q[g]),
            .priv_i    (priv_i),
            .lines_i   (ev_i),
            .sw_inc_i  (swinc_vec[g]),
            .clr_i     (clr_evt),
            .wr_cnt_i  (wr_sel_cnt && sel_q == 5'(g)),
            .wr_type_i (wr_sel_type && sel_q == 5'(g)),
            .wdata_i   (bus_wdata_i),
            .count_o   (evt_count[g]),
            .type_o    (evt_type[g]),
            .wrap_o    (evt_wrap[g])
        );
    end

    // Gather wrap pulses into the shared bitmap layout.
    always_comb begin
        wrap_vec               = '0;
        wrap_vec[NUM_EVT-1:0]  = evt_wrap;
        wrap_vec[CYC_BIT]      = cyc_wrap;
    end

    // Overflow flags: wraps set, write-one clears, set wins.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ovf_q <= '0;
        else         ovf_q <= ((ovf_q & ~(wr_ovf ? bus_wdata_i : 32'h0)) | wrap_vec) & IMPL_MASK;
    end

    assign irq_o = |(ovf_q & ie_q);

    // Indirect view of the selected general counter.
    always_comb begin
        sel_count = '0;
        sel_type  = '0;
        sel_valid = sel_q < NUM_EVT_F;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_q == 5'(i)) begin
                sel_count = evt_count[i];
                sel_type  = evt_type[i];
            end
        end
    end

    assign user_blocked = (priv_i == PRIV_USER) && !user_q;

    // Combinational read mux.
    always_comb begin
        case (bus_addr_i)
            A_CTRL:               bus_rdata_o = {16'h0, NUM_EVT_F, 5'h0, ctrl_q};
            A_EN_SET, A_EN_CLR:   bus_rdata_o = en_q;
            A_IE_SET, A_IE_CLR:   bus_rdata_o = ie_q;
            A_OVF:                bus_rdata_o = ovf_q;
            A_SEL:                bus_rdata_o = {27'h0, sel_q};
            A_SEL_CNT:            bus_rdata_o = (sel_valid && !user_blocked) ? sel_count : '0;
            A_SEL_TYPE:           bus_rdata_o = sel_valid ? sel_type : '0;
            A_CYC:                bus_rdata_o = user_blocked ? '0 : cyc_count;
            A_USER:               bus_rdata_o = {31'h0, user_q};
            default:              bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pmu_checker.sv
// Concurrent checks for the performance monitor counter unit.
// Assumes it is bound into perf_mon_unit and sees its internal state.
module pmu_checker
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        bus_wr_i,
    input logic [3:0]  bus_addr_i,
    input logic        wd1_i,
    input logic        wd2_i,
    input logic        wd31_i,
    input logic [4:0]  rd_field_i,
    input logic        irq_i,
    input logic        glob_en_i,
    input logic        ovf31_i,
    input logic        en31_i,
    input logic [31:0] wrap_vec_i,
    input logic [31:0] cyc_count_i,
    input logic [31:0] evt0_count_i
);
    assert_ctrl_field_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_i == A_CTRL |-> rd_field_i == 5'(NUM_EVT));

    assert_evt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i && bus_addr_i == A_CTRL && wd1_i |=> evt0_count_i == 32'h0);

    assert_cyc_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i && bus_addr_i == A_CTRL && wd2_i |=> cyc_count_i == 32'h0);

    assert_cyc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glob_en_i && !bus_wr_i |=> $stable(cyc_count_i));

    assert_en_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i && bus_addr_i == A_EN_SET && wd31_i |=> en31_i);

    assert_ovf_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_vec_i[31] |=> ovf31_i);

    assert_ovf_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i && bus_addr_i == A_OVF && wd31_i && !wrap_vec_i[31] |=> !ovf31_i);

    assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> $past(wrap_vec_i != 32'h0 || (bus_wr_i && bus_addr_i == A_IE_SET)));

    assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_i) |-> $past(bus_wr_i && (bus_addr_i == A_OVF || bus_addr_i == A_IE_CLR)));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_EVT(NUM_EVT)) i_pmu_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .wd1_i        (bus_wdata_i[1]),
    .wd2_i        (bus_wdata_i[2]),
    .wd31_i       (bus_wdata_i[31]),
    .rd_field_i   (bus_rdata_o[15:11]),
    .irq_i        (irq_o),
    .glob_en_i    (ctrl_q[0]),
    .ovf31_i      (ovf_q[31]),
    .en31_i       (en_q[31]),
    .wrap_vec_i   (wrap_vec),
    .cyc_count_i  (cyc_count),
    .evt0_count_i (evt_count[0])
);

// File: tb/test_perf_mon_unit.sv
// Self-checking bench: sweeps event numbers, privilege filters and
// counter modes with expected values computed arithmetically.
module test_perf_mon_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NEV = 4;
    localparam int NLN = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [3:0]     bus_addr = 4'd0;
    logic [31:0]    bus_wdata = 32'h0;
    logic [31:0]    bus_rdata;
    logic [1:0]     priv = 2'd1;
    logic [NLN-1:0] ev = '0;
    logic           irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_mon_unit #(.NUM_EVT(NEV), .NUM_LINES(NLN)) i_perf_mon_unit (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .priv_i(priv),
        .ev_i(ev), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [NLN-1:0] pat(input int c, input int n);
        logic [NLN-1:0] p;
        for (int j = 0; j < NLN; j++) p[j] = ((c + n) % (j + 1)) == 0;
        return p;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep [NEV];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and control layout
        rd(4'd0, v);  chk("R1 ctrl reset", v, 32'h0000_2000);
        rd(4'd1, v);  chk("R1 enable reset", v, 32'h0);
        rd(4'd5, v);  chk("R1 overflow reset", v, 32'h0);
        rd(4'd10, v); chk("R1 cycle reset", v, 32'h0);
        chk("R6 irq reset", 32'(irq), 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);  chk("R1 ctrl writable bits", v, 32'h0000_2039);
        wr(4'd0, 32'h0);

        // R4 set/clear bitmaps
        wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); chk("R4 enable set", v, 32'h8000_000F);
        wr(4'd2, 32'h0000_0005); rd(4'd2, v); chk("R4 enable clear", v, 32'h8000_000A);
        wr(4'd1, 32'h0);         rd(4'd1, v); chk("R4 zero set no effect", v, 32'h8000_000A);
        wr(4'd2, 32'h0);         rd(4'd1, v); chk("R4 zero clear no effect", v, 32'h8000_000A);
        wr(4'd3, 32'h8000_0003); rd(4'd4, v); chk("R4 irq enable set", v, 32'h8000_0003);
        wr(4'd4, 32'hFFFF_FFFF); rd(4'd3, v); chk("R4 irq enable clear", v, 32'h0);

        // R8 type mask
        wr(4'd7, 32'd1); wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v); chk("R8 type mask", v, 32'hC800_03FF);
        wr(4'd9, 32'h0);

        // R3 cycle counter normal and divided
        wr(4'd2, 32'hFFFF_FFFF); wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h5);
        repeat (37) @(negedge clk);
        rd(4'd10, v); chk("R3 cycle count", v, 32'd37);
        wr(4'd0, 32'hD);
        repeat (63) @(negedge clk);
        rd(4'd10, v); chk("R3 div64 before tick", v, 32'd0);
        @(negedge clk);
        rd(4'd10, v); chk("R3 div64 first tick", v, 32'd1);
        repeat (100) @(negedge clk);
        rd(4'd10, v); chk("R3 div64 ratio", v, 32'(164 / 64));
        wr(4'd0, 32'h1);
        repeat (5) @(negedge clk);
        wr(4'd0, 32'h5);
        rd(4'd10, v); chk("R2 cycle clear beats increment", v, 32'd0);
        wr(4'd10, 32'd1000);
        rd(4'd10, v); chk("R11 cycle load beats increment", v, 32'd1000);
        wr(4'd0, 32'h0);
        rd(4'd10, v);
        repeat (10) @(negedge clk);
        rd(4'd10, keep[0]); chk("R3 global disable holds", keep[0], v);

        // R10 user-level access gating
        priv = 2'd0;
        rd(4'd10, v); chk("R10 user read blocked", v, 32'h0);
        wr(4'd11, 32'h1);
        rd(4'd11, v); chk("R10 user write ignored", v, 32'h0);
        priv = 2'd1;
        wr(4'd11, 32'h1);
        priv = 2'd0;
        rd(4'd10, v); chk("R10 user read allowed", v, keep[0]);
        priv = 2'd1;
        wr(4'd11, 32'h0);

        // R8 event number sweep over every counter
        for (int n = 0; n < NEV; n++) begin
            for (int ei = 0; ei < 10; ei++) begin
                int e;
                int exp;
                e = (ei == 9) ? 17 : ei;
                wr(4'd0, 32'h2);
                wr(4'd2, 32'hFFFF_FFFF);
                wr(4'd1, 32'h1 << n);
                wr(4'd7, 32'(n));
                wr(4'd9, 32'(e));
                wr(4'd0, 32'h3);
                exp = 0;
                for (int c = 0; c < 12; c++) begin
                    ev = pat(c, n);
                    if (e == 17) exp++;
                    else if (e >= 1 && e < NLN && pat(c, n)[e]) exp++;
                    @(negedge clk);
                end
                ev = '0;
                rd(4'd8, v);
                chk($sformatf("R8 counter %0d event %0d", n, e), v, 32'(exp));
            end
        end

        // R9 privilege filter matrix on counter 0
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 8; f++) begin
                logic [31:0] t;
                logic ok;
                t = 32'h11 | (32'(f & 1) << 27) | (32'((f >> 1) & 1) << 30) | (32'((f >> 2) & 1) << 31);
                case (p)
                    0: ok = ((f >> 1) & 1) == 0;
                    1: ok = ((f >> 2) & 1) == 0;
                    2: ok = (f & 1) == 1;
                    default: ok = 1'b0;
                endcase
                wr(4'd0, 32'h2);
                wr(4'd2, 32'hFFFF_FFFF);
                wr(4'd1, 32'h1);
                wr(4'd7, 32'd0);
                wr(4'd9, t);
                wr(4'd0, 32'h3);
                priv = 2'(p);
                repeat (5) @(negedge clk);
                priv = 2'd1;
                rd(4'd8, v);
                chk($sformatf("R9 priv %0d filter %0d", p, f), v, ok ? 32'd5 : 32'd0);
            end
        end

        // R8 software increment selects counters by bit
        wr(4'd0, 32'h2);
        for (int n = 0; n < NEV; n++) begin wr(4'd7, 32'(n)); wr(4'd9, 32'h0); end
        wr(4'd1, 32'hF);
        wr(4'd0, 32'h1);
        wr(4'd6, 32'h2); wr(4'd6, 32'h2); wr(4'd6, 32'h2); wr(4'd6, 32'h4);
        wr(4'd7, 32'd0); rd(4'd8, v); chk("R8 swinc counter 0", v, 32'd0);
        wr(4'd7, 32'd1); rd(4'd8, v); chk("R8 swinc counter 1", v, 32'd3);
        wr(4'd7, 32'd2); rd(4'd8, v); chk("R8 swinc counter 2", v, 32'd1);
        wr(4'd0, 32'h2);
        rd(4'd8, v); chk("R2 event clear", v, 32'd0);

        // R7 out-of-range select
        for (int n = 0; n < NEV; n++) begin
            wr(4'd7, 32'(n)); wr(4'd8, 32'(100 + n)); rd(4'd8, keep[n]);
            chk("R11 indirect load", keep[n], 32'(100 + n));
        end
        wr(4'd7, 32'(NEV));
        wr(4'd8, 32'd55);
        rd(4'd8, v); chk("R7 out of range count", v, 32'h0);
        rd(4'd9, v); chk("R7 out of range type", v, 32'h0);
        for (int n = 0; n < NEV; n++) begin
            wr(4'd7, 32'(n)); rd(4'd8, v); chk("R7 counters untouched", v, keep[n]);
        end

        // R5 R6 overflow on counter 2 and interrupt
        wr(4'd0, 32'h0);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd7, 32'd2); wr(4'd9, 32'h11); wr(4'd8, 32'hFFFF_FFFE);
        rd(4'd5, v); chk("R11 load sets no flag", v, 32'h0);
        wr(4'd1, 32'h4); wr(4'd3, 32'h4);
        wr(4'd0, 32'h1);
        @(negedge clk);
        rd(4'd8, v); chk("R5 count at max", v, 32'hFFFF_FFFF);
        rd(4'd5, v); chk("R5 no flag before wrap", v, 32'h0);
        chk("R6 irq low before wrap", 32'(irq), 32'h0);
        @(negedge clk);
        rd(4'd5, v); chk("R5 flag on wrap", v, 32'h4);
        chk("R6 irq high on flag", 32'(irq), 32'h1);
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h4);
        chk("R6 irq low when disabled", 32'(irq), 32'h0);
        rd(4'd5, v); chk("R5 flag kept", v, 32'h4);
        wr(4'd3, 32'h4);
        chk("R6 irq back on enable", 32'(irq), 32'h1);
        wr(4'd5, 32'h4);
        rd(4'd5, v); chk("R5 write one clears", v, 32'h0);
        chk("R6 irq low after clear", 32'(irq), 32'h0);

        // R5 cycle counter wrap lands on bit 31
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd10, 32'hFFFF_FFFF);
        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h1);
        @(negedge clk);
        rd(4'd5, v); chk("R5 cycle wrap flag bit31", v, 32'h8000_0000);
        rd(4'd10, v); chk("R5 cycle wrapped to zero", v, 32'h0);
        wr(4'd0, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule